// File: doc/BRIEF.md
# DMA Channel Address Sequencer with Repeat Windows

This block is one DMA channel that moves data one byte per beat. It holds a source address and a destination address. On every acknowledged beat it advances both addresses and decrements a transfer count. When the count reaches zero the channel drops its active bit. Either address can be confined to an aligned window of 2^N bytes, and the two windows are set independently. When an address steps past the top of its window, it returns to the window start and the address bits above the window stay as they were.

A window overflow can also stop the channel. If the halt enable for the address that overflowed is set, the channel does three things after that beat: it raises a sticky overflow flag, clears its active bit and stops requesting. It then signals an interrupt, provided the interrupt enable is on. Software restarts the channel by writing the active bit again, and transfers continue from the wrapped addresses.

Software uses a small write/read register port to program the channel and to observe it. The data movement is a request/acknowledge pair: `xfer_req` asks for a beat, and a beat happens on each clock where `xfer_ack` is high while `xfer_req` is high.

Top module: `dma_repeat_chan`

## Requirements
- R1: After reset, every register reads 0, `xfer_req` is 0 and `irq` is 0.
- R2: Each beat advances both the source and destination addresses by one under their window rules and decrements the count by one. With no window, the address rolls over from all-ones to 0 across the full width.
- R3: `xfer_req` is 1 exactly when the active bit is 1 and the count is nonzero. The active bit clears after the beat that takes the count to 0.
- R4: A source window value N from 1 to ADDR_W-1 makes the low N bits count modulo 2^N while the upper bits are held. For example, with N=3, 0x240007 is followed by 0x240000.
- R5: The destination window works in the same way, and its size is independent of the source window.
- R6: A window value of 0, or any value of ADDR_W or more, disables wrapping and never reports an overflow.
- R7: A source overflow while the source halt enable (window register bit 16) is 1 sets the flag and clears the active bit after that beat, so `xfer_req` falls.
- R8: The destination halt enable (window register bit 17) does the same for destination overflows. Overflows on both addresses in the same beat cause one halt.
- R9: An overflow whose halt enable is 0 leaves the flag unchanged and lets transfers continue.
- R10: `irq` equals the overflow flag ANDed with the interrupt enable.
- R11: The flag stays set until software writes 0 to status bit 2; writing 1 there leaves it unchanged. Writing active=1 after a halt resumes transfers from the wrapped addresses.
- R12: The register index selects one of the following, and any other index reads 0:
  - 0: source address.
  - 1: destination address.
  - 2: count.
  - 3: windows. Source window N is in bits [4:0], destination window N in bits [12:8], and the halt enables are bits 16 and 17.
  - 4: status. Bit 0 is active, bit 1 is the interrupt enable and bit 2 is the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data for `cfg_addr` |
| xfer_req | output | 1 | Beat request |
| xfer_ack | input | 1 | Beat acknowledge |
| xfer_src | output | ADDR_W | Current source address |
| xfer_dst | output | ADDR_W | Current destination address |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default widths: 24-bit addresses and a 16-bit count. With 24-bit addresses, a start address near 0xFFFFFF reaches the full-width rollover in a few beats. The 5-bit window field can also hold values from 24 to 31, so the bench reaches the out-of-range window settings as well. Window sizes from 2 to 64 bytes and short counts make wraps, halts and resumes occur many times in each random run.

// File: rtl/dmarpt_pkg.sv
package dmarpt_pkg;
  localparam int AREA_W = 5;

  typedef enum logic [2:0] {
    REG_SRC  = 3'd0,
    REG_DST  = 3'd1,
    REG_CNT  = 3'd2,
    REG_WIN  = 3'd3,
    REG_STAT = 3'd4
  } reg_idx_e;

  localparam int SRC_AREA_LSB = 0;
  localparam int DST_AREA_LSB = 8;
  localparam int SRC_HALT_BIT = 16;
  localparam int DST_HALT_BIT = 17;
  localparam int STAT_ACT_BIT = 0;
  localparam int STAT_IE_BIT  = 1;
  localparam int STAT_OVF_BIT = 2;
endpackage

// File: rtl/dmarpt_addr_step.sv
module dmarpt_addr_step
  import dmarpt_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [AREA_W-1:0] area,
  output logic [ADDR_W-1:0] nxt,
  output logic              wrap_evt
);
  // Window mask: zero means "no window" (area 0 or out of range).
  function automatic logic [ADDR_W-1:0] win_mask(input logic [AREA_W-1:0] n);
    logic [ADDR_W-1:0] one;
    one = {{(ADDR_W-1){1'b0}}, 1'b1};
    if (n == '0 || 32'(n) >= ADDR_W) return '0;
    return (one << n) - one;
  endfunction

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] inc;
    inc = a + 1'b1;
    if (m == '0) return inc;
    return (a & ~m) | (inc & m);
  endfunction

  logic [ADDR_W-1:0] mask;

  always_comb begin
    mask     = win_mask(area);
    nxt      = step(cur, mask);
    wrap_evt = (mask != '0) && ((cur & mask) == mask);
  end
endmodule

// File: rtl/dmarpt_seq.sv
module dmarpt_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             src_wrap,
  input  logic             dst_wrap,
  input  logic             src_halt_en,
  input  logic             dst_halt_en,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             stat_we,
  input  logic [2:0]       stat_wdata,
  output logic             active,
  output logic             ie,
  output logic             ovf_flag,
  output logic [CNT_W-1:0] count,
  output logic             req,
  output logic             beat,
  output logic             halt_evt
);
  logic last_beat;

  always_comb begin
    req       = active && (count != '0);
    beat      = req && ack;
    halt_evt  = beat && ((src_wrap && src_halt_en) || (dst_wrap && dst_halt_en));
    last_beat = beat && (count == {{(CNT_W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ie       <= 1'b0;
      ovf_flag <= 1'b0;
    end else if (stat_we) begin
      active   <= stat_wdata[0];
      ie       <= stat_wdata[1];
      ovf_flag <= ovf_flag & stat_wdata[2];
    end else if (halt_evt) begin
      ovf_flag <= 1'b1;
      active   <= 1'b0;
    end else if (last_beat || (active && count == '0)) begin
      active   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_we) count <= cnt_wdata;
    else if (beat)   count <= count - 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !cnt_we |=> count == $past(count) - 1'b1); // R2
  AST_LAST_BEAT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat && !cnt_we && !stat_we |=> !req); // R3
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt && !stat_we |=> ovf_flag && !active && !req); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(stat_we && !stat_wdata[2]) |=> ovf_flag); // R11
endmodule

// File: rtl/dma_repeat_chan.sv
module dma_repeat_chan
  import dmarpt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              xfer_req,
  input  logic              xfer_ack,
  output logic [ADDR_W-1:0] xfer_src,
  output logic [ADDR_W-1:0] xfer_dst,
  output logic              irq
);
  localparam int NCH = 2; // 0: source, 1: destination

  logic [ADDR_W-1:0] addr_q [NCH];
  logic [ADDR_W-1:0] addr_n [NCH];
  logic [AREA_W-1:0] area_q [NCH];
  logic              halt_q [NCH];
  logic              wrap   [NCH];
  logic              addr_we[NCH];

  logic              win_we, cnt_we, stat_we;
  logic              active, ie, ovf_flag, beat, halt_evt;
  logic [CNT_W-1:0]  count;

  always_comb begin
    addr_we[0] = cfg_we && (cfg_addr == 3'(REG_SRC));
    addr_we[1] = cfg_we && (cfg_addr == 3'(REG_DST));
    cnt_we     = cfg_we && (cfg_addr == 3'(REG_CNT));
    win_we     = cfg_we && (cfg_addr == 3'(REG_WIN));
    stat_we    = cfg_we && (cfg_addr == 3'(REG_STAT));
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam int AREA_LSB = (g == 0) ? SRC_AREA_LSB : DST_AREA_LSB;
    localparam int HALT_BIT = (g == 0) ? SRC_HALT_BIT : DST_HALT_BIT;

    dmarpt_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .cur      (addr_q[g]),
      .area     (area_q[g]),
      .nxt      (addr_n[g]),
      .wrap_evt (wrap[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr_q[g] <= '0;
      else if (addr_we[g]) addr_q[g] <= cfg_wdata;
      else if (beat)       addr_q[g] <= addr_n[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        area_q[g] <= '0;
        halt_q[g] <= 1'b0;
      end else if (win_we) begin
        area_q[g] <= cfg_wdata[AREA_LSB +: AREA_W];
        halt_q[g] <= cfg_wdata[HALT_BIT];
      end
    end

    AST_WRAP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      beat && wrap[g] && !addr_we[g] |=> addr_q[g] < $past(addr_q[g])); // R4 R5
    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      beat && !wrap[g] && !addr_we[g] |=> addr_q[g] == $past(addr_q[g]) + 1'b1); // R2 R6
  end

  dmarpt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (xfer_ack),
    .src_wrap    (wrap[0]),
    .dst_wrap    (wrap[1]),
    .src_halt_en (halt_q[0]),
    .dst_halt_en (halt_q[1]),
    .cnt_we      (cnt_we),
    .cnt_wdata   (cfg_wdata[CNT_W-1:0]),
    .stat_we     (stat_we),
    .stat_wdata  (cfg_wdata[2:0]),
    .active      (active),
    .ie          (ie),
    .ovf_flag    (ovf_flag),
    .count       (count),
    .req         (xfer_req),
    .beat        (beat),
    .halt_evt    (halt_evt)
  );

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      3'(REG_SRC): cfg_rdata = addr_q[0];
      3'(REG_DST): cfg_rdata = addr_q[1];
      3'(REG_CNT): cfg_rdata = ADDR_W'(count);
      3'(REG_WIN): begin
        cfg_rdata[SRC_AREA_LSB +: AREA_W] = area_q[0];
        cfg_rdata[DST_AREA_LSB +: AREA_W] = area_q[1];
        cfg_rdata[SRC_HALT_BIT]           = halt_q[0];
        cfg_rdata[DST_HALT_BIT]           = halt_q[1];
      end
      3'(REG_STAT): begin
        cfg_rdata[STAT_ACT_BIT] = active;
        cfg_rdata[STAT_IE_BIT]  = ie;
        cfg_rdata[STAT_OVF_BIT] = ovf_flag;
      end
      default: cfg_rdata = '0;
    endcase
  end

  assign xfer_src = addr_q[0];
  assign xfer_dst = addr_q[1];
  assign irq      = ovf_flag & ie;

  AST_IRQ_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt && ie && !stat_we |=> irq); // R10
  AST_NO_HALT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !halt_evt && !ovf_flag && !stat_we |=> !ovf_flag); // R9
endmodule

// File: tb/test_dma_repeat_chan.sv
`timescale 1ns/1ps
module test_dma_repeat_chan;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          xfer_req, xfer_ack = 1'b0, irq;
  logic [AW-1:0] xfer_src, xfer_dst;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference state
  logic [23:0] m_src, m_dst;
  int          m_cnt, m_sa, m_da;
  bit          m_act, m_ie, m_flag, m_sh, m_dh;

  always #2.5 clk = ~clk;

  dma_repeat_chan i_dma_repeat_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_req(xfer_req),
    .xfer_ack(xfer_ack), .xfer_src(xfer_src), .xfer_dst(xfer_dst), .irq(irq));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Window rule restated as base + offset modulo window size.
  function automatic logic [23:0] mdl_next(logic [23:0] a, int n);
    int sz, off, base;
    if (n == 0 || n >= 24) return a + 24'd1;
    sz = 1 << n;
    off = int'(a) % sz;
    base = int'(a) - off;
    return 24'(base + ((off + 1) % sz));
  endfunction

  function automatic bit mdl_wrap(logic [23:0] a, int n);
    if (n == 0 || n >= 24) return 0;
    return (int'(a) % (1 << n)) == (1 << n) - 1;
  endfunction

  task automatic wr(int idx, logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (idx)
      0: m_src = d;
      1: m_dst = d;
      2: m_cnt = int'(d[15:0]);
      3: begin m_sa = int'(d[4:0]); m_da = int'(d[12:8]); m_sh = d[16]; m_dh = d[17]; end
      4: begin m_act = d[0]; m_ie = d[1]; m_flag = m_flag & d[2]; end
      default: ;
    endcase
  endtask

  task automatic rd_chk(string tag, int idx, logic [23:0] exp);
    cfg_addr = 3'(idx);
    #0.5;
    chk(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  // Run beats with a random acknowledge until the reference goes idle.
  task automatic run();
    int guard = 0;
    bit a;
    while (m_act && guard < 600) begin
      @(negedge clk);
      chk("R2 src", 32'(xfer_src), 32'(m_src));
      chk("R2 dst", 32'(xfer_dst), 32'(m_dst));
      chk("R3 req", 32'(xfer_req), 32'(m_act && m_cnt != 0));
      chk("R10 irq", 32'(irq), 32'(m_flag & m_ie));
      a = ($urandom % 3) != 0;
      xfer_ack = a;
      if (a && m_act && m_cnt != 0) begin
        bit ws, wd;
        ws = mdl_wrap(m_src, m_sa);
        wd = mdl_wrap(m_dst, m_da);
        m_src = mdl_next(m_src, m_sa);
        m_dst = mdl_next(m_dst, m_da);
        m_cnt--;
        if ((ws && m_sh) || (wd && m_dh)) begin m_flag = 1; m_act = 0; end
        else if (m_cnt == 0) m_act = 0;
      end
      guard++;
    end
    @(negedge clk);
    xfer_ack = 1'b0;
    chk("R3 idle req", 32'(xfer_req), 0);
    chk("R11 flag", 32'(irq), 32'(m_flag & m_ie));
    rd_chk("R12 count", 2, 24'(m_cnt));
  endtask

  task automatic setup(logic [23:0] s, logic [23:0] d, int cnt, int sa, int da,
                       bit sh, bit dh, bit ie);
    wr(0, s); wr(1, d); wr(2, 24'(cnt));
    wr(3, 24'(sa) | (24'(da) << 8) | (24'(sh) << 16) | (24'(dh) << 17));
    wr(4, {21'd0, 1'b0, ie, 1'b1});
  endtask

  initial begin
    void'($urandom(32'h5EED));
    m_src = 0; m_dst = 0; m_cnt = 0; m_sa = 0; m_da = 0;
    m_act = 0; m_ie = 0; m_flag = 0; m_sh = 0; m_dh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) rd_chk("R1 reg reset", i, 24'd0);
    chk("R1 req reset", 32'(xfer_req), 0);
    chk("R1 irq reset", 32'(irq), 0);

    // R4 example window of 8 bytes, no halt -> R9 continues
    setup(24'h240005, 24'h100000, 5, 3, 0, 0, 0, 0);
    run();
    chk("R4 src wrapped", 32'(xfer_src), 32'h240002);
    chk("R5 dst free", 32'(xfer_dst), 32'h100005);
    rd_chk("R9 no flag", 4, 24'd0);

    // R6 full-width rollover, area 0 and area 30
    setup(24'hFFFFFE, 24'hFFFFFD, 3, 30, 0, 1, 1, 1);
    run();
    chk("R6 src roll", 32'(xfer_src), 32'h000001);
    chk("R6 dst roll", 32'(xfer_dst), 32'h000000);
    rd_chk("R6 no flag", 4, 24'd2);

    // R7 source halt, then R11 resume and clear
    setup(24'h000002, 24'h000050, 10, 2, 0, 1, 0, 1);
    run();
    chk("R7 src wrapped", 32'(xfer_src), 32'h000000);
    rd_chk("R7 count", 2, 24'd8);
    rd_chk("R7 status", 4, 24'd6);
    chk("R10 irq high", 32'(irq), 1);
    wr(4, 24'd7);
    rd_chk("R11 flag kept", 4, 24'd7);
    run();
    wr(4, 24'd2);
    chk("R11 cleared irq", 32'(irq), 0);
    rd_chk("R11 status", 4, 24'd2);

    // R8 simultaneous overflow: one halt
    setup(24'h000001, 24'h000003, 4, 1, 1, 1, 1, 0);
    run();
    chk("R8 src", 32'(xfer_src), 32'h000000);
    chk("R8 dst", 32'(xfer_dst), 32'h000002);
    rd_chk("R8 count", 2, 24'd3);
    rd_chk("R8 status", 4, 24'd4);
    chk("R10 irq masked", 32'(irq), 0);
    rd_chk("R12 window", 3, 24'h030101);
    wr(4, 24'd0);

    // random runs
    for (int t = 0; t < 60; t++) begin
      int sa, da;
      sa = ($urandom % 4 == 0) ? 24 + int'($urandom % 8) : int'($urandom % 7);
      da = ($urandom % 4 == 0) ? 24 + int'($urandom % 8) : int'($urandom % 7);
      setup(24'($urandom), 24'($urandom), 1 + int'($urandom % 24), sa, da,
            $urandom % 2 == 0, $urandom % 2 == 0, $urandom % 2 == 0);
      run();
      for (int k = 0; k < 3 && m_flag && m_cnt != 0; k++) begin
        wr(4, {21'd0, 1'($urandom % 2), m_ie, 1'b1});
        run();
      end
      wr(4, 24'd0);
      rd_chk("R11 cleared", 4, 24'd0);
    end

    summary();
    $finish;
  end
endmodule